// File: doc/BRIEF.md
# Security-Banked Interrupt Priority Filter

This block is one slice of an interrupt controller serving a single processor. It holds an 8-bit priority, a group bit and an enable bit for each of 32 interrupt sources, along with a priority mask and a control register with two group enables. Each cycle it compares the pending inputs against this state. It forwards the most urgent qualifying source as a registered request carrying that source's ID. A lower priority number means more urgent.

Configuration arrives over a simple register bus. Every access carries a security attribute. Secure accesses see and store raw values. Non-secure accesses get a restricted view:
- Non-secure software can only touch Group 1 sources.
- Its priority writes are halved and pushed into the less urgent half of the range.
- It loses access to the mask entirely once secure software has placed the mask in the more urgent half.

Firmware uses this to hand a subset of interrupts to a less trusted OS. That OS can never mask or outrank the sources kept by the secure side.

Top module: `prio_sec_filter`

Register map (word addresses on `addr`): 0x00 control, 0x01 mask, 0x02 group bits (bit n = source n, 1 = Group 1), 0x03 enable bits (bit n = source n), 0x20+n priority of source n in data bits [7:0]. Unused data bits read as 0. Writes happen when `wr_en` is high at a clock edge. Reads are combinational on `addr` and `sec`.

## Requirements
- R1: After reset, all priorities, the mask, the group bits, the enable bits and both group enables are 0, and `irq_req` and `irq_id` are 0.
- R2: A non-secure write to the priority of a Group 1 source stores {1, wdata[7:1]}. A non-secure read of that priority returns {stored[6:0], 0}. Secure accesses store and read the raw 8-bit value.
- R3: Non-secure accesses cannot change Group 0 configuration:
  - A non-secure write to a Group 0 priority leaves it unchanged, and a non-secure read of it returns 0.
  - A non-secure write to the enable register changes only Group 1 bits, and a non-secure read of it shows only Group 1 bits.
  - The group register is secure-only: non-secure writes are ignored and non-secure reads return 0.
- R4: While the stored mask is below 0x80, a non-secure read of the mask returns 0x00 and a non-secure write to it is ignored.
- R5: While the stored mask is 0x80 or above, a non-secure mask write stores {1, wdata[7:1]} and a non-secure mask read returns {stored[6:0], 0}.
- R6: A source is forwarded only if its priority value is strictly lower than the stored mask.
- R7: A source takes part in selection only when three conditions hold:
  - its pending input is high;
  - its enable bit is set;
  - the control enable of its group is set.
- R8: The control register has two views:
  - Secure view: bit 0 enables Group 0 and bit 1 enables Group 1.
  - Non-secure view: bit 0 is the Group 1 enable and other bits read 0. A non-secure write to bit 0 changes only the Group 1 enable.
- R9: Among qualifying sources the lowest priority value wins, and ties go to the lowest source ID.
- R10: `irq_req` and `irq_id` are registered. They show the selection made from the state and pending inputs present before the previous clock edge. `irq_id` is 0 while `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| sec | input | 1 | Access security attribute, 1 = secure |
| addr | input | 6 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` under the `sec` view |
| irq_pend | input | 32 | Pending level of each source |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_id | output | 5 | ID of the forwarded source |

## Verification
Most internal faults surface on the read port in the same cycle they occur, because every stored field can be read back under both views. A misconverted priority or mask, or a Group 0 field altered by a non-secure write, therefore shows up immediately in `rdata`. A fault in qualification or arbitration shows up one clock after the pending inputs settle:
- a wrong `irq_id` when priorities tie or sit exactly at the mask;
- a request that should have been held back;
- a request that is missing.

// File: rtl/psf_pkg.sv
// Package psf_pkg: register word offsets shared by the filter's modules.
// Assumes the priority window begins at PRIO_OFS and holds one word per source.
package psf_pkg;
    localparam int CTRL_OFS = 'h00;
    localparam int MASK_OFS = 'h01;
    localparam int GRP_OFS  = 'h02;
    localparam int EN_OFS   = 'h03;
    localparam int PRIO_OFS = 'h20;
endpackage

// File: rtl/psf_ctrl_regs.sv
// Module psf_ctrl_regs: holds the control enables, the priority mask, the
// group bits and the per-source enable bits, and applies the secure and
// non-secure views to each of them.
// Assumes NUM_IRQ <= DATA_W and PRIO_W <= DATA_W.
module psf_ctrl_regs
    import psf_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 8,
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               sec,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic               g0_en,
    output logic               g1_en,
    output logic [PRIO_W-1:0]  mask,
    output logic [NUM_IRQ-1:0] grp,
    output logic [NUM_IRQ-1:0] en,
    output logic               hit,
    output logic [DATA_W-1:0]  rd_data
);
    localparam logic [PRIO_W-1:0] HALF = PRIO_W'(1) << (PRIO_W - 1);

    logic hit_ctrl, hit_mask, hit_grp, hit_en;
    logic ns_mask_open;
    logic [PRIO_W-1:0] mask_ns_wr;

    assign hit_ctrl     = (addr == ADDR_W'(CTRL_OFS));
    assign hit_mask     = (addr == ADDR_W'(MASK_OFS));
    assign hit_grp      = (addr == ADDR_W'(GRP_OFS));
    assign hit_en       = (addr == ADDR_W'(EN_OFS));
    assign hit          = hit_ctrl | hit_mask | hit_grp | hit_en;
    assign ns_mask_open = (mask >= HALF);
    assign mask_ns_wr   = {1'b1, wdata[PRIO_W-1:1]};

    // Control enables: the secure view has both group bits, the non-secure view only Group 1 at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g0_en <= 1'b0;
            g1_en <= 1'b0;
        end else if (wr_en && hit_ctrl) begin
            if (sec) begin
                g0_en <= wdata[0];
                g1_en <= wdata[1];
            end else begin
                g1_en <= wdata[0];
            end
        end
    end

    // Mask: raw secure writes; non-secure writes are halved and land only while the mask is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (wr_en && hit_mask) begin
            if (sec) begin
                mask <= wdata[PRIO_W-1:0];
            end else if (ns_mask_open) begin
                mask <= mask_ns_wr;
            end
        end
    end

    // Group bits: writable by secure accesses only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp <= '0;
        end else if (wr_en && hit_grp && sec) begin
            grp <= wdata[NUM_IRQ-1:0];
        end
    end

    // Enable bits: non-secure writes merge into the Group 1 positions only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
        end else if (wr_en && hit_en) begin
            if (sec) begin
                en <= wdata[NUM_IRQ-1:0];
            end else begin
                en <= (en & ~grp) | (wdata[NUM_IRQ-1:0] & grp);
            end
        end
    end

    // Read view: choose the secure or the non-secure presentation of the addressed register.
    always_comb begin
        rd_data = '0;
        if (hit_ctrl) begin
            if (sec) begin
                rd_data[1:0] = {g1_en, g0_en};
            end else begin
                rd_data[0] = g1_en;
            end
        end else if (hit_mask) begin
            if (sec) begin
                rd_data[PRIO_W-1:0] = mask;
            end else if (ns_mask_open) begin
                rd_data[PRIO_W-1:0] = {mask[PRIO_W-2:0], 1'b0};
            end
        end else if (hit_grp) begin
            if (sec) begin
                rd_data[NUM_IRQ-1:0] = grp;
            end
        end else if (hit_en) begin
            rd_data[NUM_IRQ-1:0] = sec ? en : (en & grp);
        end
    end

    AST_MASK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sec && hit_mask && mask < HALF) |=> (mask == $past(mask))); // R4
    AST_MASK_NS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sec && hit_mask && mask >= HALF) |=> mask[PRIO_W-1]); // R5
    AST_GRP_SECURE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sec && hit_grp) |=> (grp == $past(grp))); // R3
    AST_EN_G0_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sec && hit_en) |=> ((en & ~grp) == $past(en & ~grp))); // R3
    AST_CTRL_NS_G0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sec && hit_ctrl) |=> $stable(g0_en)); // R8
endmodule

// File: rtl/psf_prio_bank.sv
// Module psf_prio_bank: one priority field per source, with the non-secure
// halving on write and the doubled, Group 1 only view on read.
// Assumes the window PRIO_OFS..PRIO_OFS+NUM_IRQ-1 fits inside the address space.
module psf_prio_bank
    import psf_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 8,
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            sec,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    input  logic [NUM_IRQ-1:0]              grp,
    output logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio,
    output logic                            hit,
    output logic [DATA_W-1:0]               rd_data
);
    localparam int ID_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    logic [ADDR_W-1:0] off;
    logic [ID_W-1:0]   idx;
    logic [PRIO_W-1:0] ns_val;

    assign off    = addr - ADDR_W'(PRIO_OFS);
    assign hit    = (addr >= ADDR_W'(PRIO_OFS)) && (off < ADDR_W'(NUM_IRQ));
    assign idx    = off[ID_W-1:0];
    assign ns_val = {1'b1, wdata[PRIO_W-1:1]};

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_field
        logic sel_me;
        assign sel_me = wr_en && hit && (idx == ID_W'(i));
        // Field i: raw secure store, halved non-secure store for Group 1 sources only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio[i] <= '0;
            end else if (sel_me && (sec || grp[i])) begin
                prio[i] <= sec ? wdata[PRIO_W-1:0] : ns_val;
            end
        end
    end

    // Read view: raw for secure, doubled for non-secure Group 1, zero for non-secure Group 0.
    always_comb begin
        rd_data = '0;
        if (hit) begin
            if (sec) begin
                rd_data[PRIO_W-1:0] = prio[idx];
            end else if (grp[idx]) begin
                rd_data[PRIO_W-1:0] = {prio[idx][PRIO_W-2:0], 1'b0};
            end
        end
    end

    AST_NS_PRIO_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sec && hit && grp[idx]) |=> prio[$past(idx)][PRIO_W-1]); // R2
    AST_NS_G0_PRIO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sec && hit && !grp[idx]) |=> (prio[$past(idx)] == $past(prio[idx]))); // R3
endmodule

// File: rtl/psf_select.sv
// Module psf_select: combinational search for the most urgent qualifying
// source. Lowest value wins and the earliest ID keeps ties.
// Assumes prio and mask use the same width and ordering.
module psf_select #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 8,
    parameter int ID_W    = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_IRQ-1:0]              pend,
    input  logic [NUM_IRQ-1:0]              en,
    input  logic [NUM_IRQ-1:0]              grp,
    input  logic                            g0_en,
    input  logic                            g1_en,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio,
    input  logic [PRIO_W-1:0]               mask,
    output logic                            sel_valid,
    output logic [ID_W-1:0]                 sel_id,
    output logic [PRIO_W-1:0]               sel_prio
);
    logic [NUM_IRQ-1:0] elig;

    // Qualification: pending, enabled, group enabled and strictly below the mask.
    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++) begin
            elig[i] = pend[i] && en[i] && (grp[i] ? g1_en : g0_en) && (prio[i] < mask);
        end
    end

    // Ascending scan: replace the candidate only on a strictly smaller value.
    always_comb begin
        sel_valid = 1'b0;
        sel_id    = '0;
        sel_prio  = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (elig[i] && (!sel_valid || prio[i] < sel_prio)) begin
                sel_valid = 1'b1;
                sel_id    = ID_W'(i);
                sel_prio  = prio[i];
            end
        end
    end

    AST_WIN_BELOW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (sel_prio < mask)); // R6
    AST_WIN_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (pend[sel_id] && en[sel_id])); // R7
    AST_WIN_GROUP_ON: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (grp[sel_id] ? g1_en : g0_en)); // R7
endmodule

// File: rtl/prio_sec_filter.sv
// Module prio_sec_filter: top of the security-banked priority filter. It
// joins the control registers, the priority bank and the selector, and
// registers the request and ID toward one processor.
// Assumes a single processor and level-sensitive pending inputs.
module prio_sec_filter #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 8,
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 32,
    localparam int ID_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               sec,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic [NUM_IRQ-1:0] irq_pend,
    output logic               irq_req,
    output logic [ID_W-1:0]    irq_id
);
    logic                            g0_en, g1_en;
    logic [PRIO_W-1:0]               mask;
    logic [NUM_IRQ-1:0]              grp, en;
    logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio;
    logic                            ctrl_hit, prio_hit;
    logic [DATA_W-1:0]               ctrl_rd, prio_rd;
    logic                            sel_valid;
    logic [ID_W-1:0]                 sel_id;
    logic [PRIO_W-1:0]               sel_prio;

    psf_ctrl_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sec(sec), .addr(addr), .wdata(wdata),
        .g0_en(g0_en), .g1_en(g1_en), .mask(mask), .grp(grp), .en(en),
        .hit(ctrl_hit), .rd_data(ctrl_rd)
    );

    psf_prio_bank #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sec(sec), .addr(addr), .wdata(wdata),
        .grp(grp), .prio(prio), .hit(prio_hit), .rd_data(prio_rd)
    );

    psf_select #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .pend(irq_pend), .en(en), .grp(grp),
        .g0_en(g0_en), .g1_en(g1_en), .prio(prio), .mask(mask),
        .sel_valid(sel_valid), .sel_id(sel_id), .sel_prio(sel_prio)
    );

    // Read mux: the two register groups decode disjoint addresses.
    assign rdata = ctrl_hit ? ctrl_rd : (prio_hit ? prio_rd : '0);

    // Output stage: register the winner toward the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_id  <= '0;
        end else begin
            irq_req <= sel_valid;
            irq_id  <= sel_valid ? sel_id : '0;
        end
    end

    AST_REQ_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_valid) |-> irq_req); // R10
    AST_ID_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_id == '0)); // R10
endmodule

// File: tb/prio_sec_filter_test.sv
module prio_sec_filter_test;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        sec = 1'b1;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [N-1:0] irq_pend = '0;
    logic        irq_req;
    logic [4:0]  irq_id;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [7:0]   m_prio [N];
    logic [7:0]   m_mask;
    logic [N-1:0] m_grp, m_en;
    logic         m_g0, m_g1;

    prio_sec_filter uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sec(sec), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_pend(irq_pend), .irq_req(irq_req), .irq_id(irq_id)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run is counted as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp<=150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] halve(logic [31:0] w);
        return {1'b1, w[7:1]};
    endfunction

    // Expected read value for an address under a given view.
    function automatic logic [31:0] exp_read(logic [5:0] a, logic s);
        logic [31:0] r = '0;
        if (a == 6'h00) r = s ? {30'd0, m_g1, m_g0} : {31'd0, m_g1};
        else if (a == 6'h01) r = s ? {24'd0, m_mask} : (m_mask >= 8'h80 ? {23'd0, m_mask[6:0], 1'b0} : 32'd0);
        else if (a == 6'h02) r = s ? m_grp : 32'd0;
        else if (a == 6'h03) r = s ? m_en : (m_en & m_grp);
        else if (a >= 6'h20) begin
            if (s) r = {24'd0, m_prio[a - 6'h20]};
            else if (m_grp[a - 6'h20]) r = {23'd0, m_prio[a - 6'h20][6:0], 1'b0};
        end
        return r;
    endfunction

    // Expected winner {valid, id}: lowest value, then lowest ID.
    function automatic logic [5:0] exp_pick(logic [N-1:0] p);
        logic v = 1'b0;
        logic [4:0] id = '0;
        logic [7:0] best = '1;
        for (int i = 0; i < N; i++) begin
            if (p[i] && m_en[i] && (m_grp[i] ? m_g1 : m_g0) && m_prio[i] < m_mask
                && (!v || m_prio[i] < best)) begin
                v = 1'b1;
                id = 5'(i);
                best = m_prio[i];
            end
        end
        return {v, id};
    endfunction

    task automatic model_write(logic [5:0] a, logic [31:0] d, logic s);
        if (a == 6'h00) begin
            if (s) begin m_g0 = d[0]; m_g1 = d[1]; end
            else m_g1 = d[0];
        end else if (a == 6'h01) begin
            if (s) m_mask = d[7:0];
            else if (m_mask >= 8'h80) m_mask = halve(d);
        end else if (a == 6'h02) begin
            if (s) m_grp = d;
        end else if (a == 6'h03) begin
            m_en = s ? d : ((m_en & ~m_grp) | (d & m_grp));
        end else if (a >= 6'h20) begin
            if (s) m_prio[a - 6'h20] = d[7:0];
            else if (m_grp[a - 6'h20]) m_prio[a - 6'h20] = halve(d);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d, logic s);
        @(negedge clk);
        addr = a; wdata = d; sec = s; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d, s);
    endtask

    task automatic rd_check(string tag, logic [5:0] a, logic s);
        addr = a; sec = s;
        #1;
        check(tag, rdata, exp_read(a, s));
    endtask

    // One more edge after the last change, then compare the registered outputs.
    task automatic irq_check(string tag);
        logic [5:0] e;
        @(negedge clk);
        e = exp_pick(irq_pend);
        check(tag, {26'd0, irq_req, irq_id}, {26'd0, e});
    endtask

    initial begin
        void'($urandom(32'h1c0ffee5));
        for (int i = 0; i < N; i++) m_prio[i] = '0;
        m_mask = '0; m_grp = '0; m_en = '0; m_g0 = 1'b0; m_g1 = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq", {31'd0, irq_req}, 32'd0);
        rd_check("R1 mask", 6'h01, 1'b1);
        rd_check("R1 ctrl", 6'h00, 1'b1);
        rd_check("R1 prio0", 6'h20, 1'b1);
        rd_check("R1 en", 6'h03, 1'b1);

        // R4: mask locked while below half
        wr(6'h01, 32'h40, 1'b1);
        rd_check("R4 ns read", 6'h01, 1'b0);
        wr(6'h01, 32'hFF, 1'b0);
        rd_check("R4 ns write ignored", 6'h01, 1'b1);

        // R5: open mask
        wr(6'h01, 32'hF0, 1'b1);
        rd_check("R5 ns read", 6'h01, 1'b0);
        wr(6'h01, 32'hFF, 1'b0);
        rd_check("R5 ns write stored", 6'h01, 1'b1);

        // R2 / R3: priority views
        wr(6'h02, 32'h0000_00A0, 1'b1);          // sources 5 and 7 are Group 1
        wr(6'h20 + 6'd5, 32'h10, 1'b0);
        rd_check("R2 secure raw", 6'h25, 1'b1);
        rd_check("R2 ns doubled", 6'h25, 1'b0);
        wr(6'h20 + 6'd3, 32'h20, 1'b1);
        wr(6'h20 + 6'd3, 32'h02, 1'b0);
        rd_check("R3 g0 prio kept", 6'h23, 1'b1);
        rd_check("R3 g0 prio hidden", 6'h23, 1'b0);
        wr(6'h02, 32'hFFFF_FFFF, 1'b0);
        rd_check("R3 grp secure only", 6'h02, 1'b1);
        wr(6'h03, 32'h0000_0008, 1'b1);
        wr(6'h03, 32'hFFFF_FFFF, 1'b0);
        rd_check("R3 en g1 only", 6'h03, 1'b1);

        // R8: banked control
        wr(6'h00, 32'h1, 1'b0);
        rd_check("R8 ns sets g1", 6'h00, 1'b1);
        rd_check("R8 ns view", 6'h00, 1'b0);

        // R6 / R9 / R7: selection corners
        wr(6'h01, 32'h88, 1'b1);
        wr(6'h27, 32'h88, 1'b1);
        irq_pend = 32'h0000_00A8;
        irq_check("R6 equal to mask masked");
        wr(6'h01, 32'h89, 1'b1);
        irq_check("R9 tie lowest id");
        wr(6'h00, 32'h3, 1'b1);
        wr(6'h23, 32'h88, 1'b1);
        irq_check("R9 tie g0 id3");
        wr(6'h00, 32'h2, 1'b1);
        irq_check("R7 g0 disabled");
        irq_pend = 32'h0;
        irq_check("R10 idle id zero");

        // Random mix, every step followed by output and readback checks.
        for (int k = 0; k < 600; k++) begin
            int op;
            logic [5:0] a;
            logic s;
            op = int'($urandom % 6);
            s = 1'($urandom);
            case (op)
                0: a = 6'h20 + 6'($urandom % N);
                1: a = 6'h01;
                2: a = 6'h02;
                3: a = 6'h03;
                4: a = 6'h00;
                default: a = 6'h20 + 6'($urandom % 4);
            endcase
            if (op == 5) begin
                @(negedge clk);
                irq_pend = $urandom;
            end else begin
                wr(a, (op == 0 || op == 5) ? {24'd0, 8'($urandom % 16) * 8'd16} : $urandom, s);
            end
            irq_check("R9 random select");
            rd_check("R2 random read", a, s);
            rd_check("R5 random mask", 6'h01, 1'($urandom));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule